// File: doc/BRIEF.md
# Interrupt Priority Grouping Resolver

This block looks at a vector of pending interrupt lines, each carrying a programmable 8-bit priority value, and names the request that should be serviced next. It also states whether that request may interrupt the handler that is currently running. A programmable 3-bit grouping field sets a binary point inside every priority value. Bits above the point form the nesting group, and only the group decides whether a handler may be interrupted. Bits below the point form a subpriority, which only orders requests that share the same group.

Only the top four bits of each priority value are stored, so there are at most sixteen distinct levels. Smaller numbers are more urgent. When two pending requests hold equal values, the lower line index wins. Software programs priorities and the grouping field through a single write port. The running handler's level is presented on the active-priority input, which is qualified by a valid bit. When no handler is running, every pending request may be taken.

The result is held in a three-state machine that is re-evaluated every cycle. In `ST_QUIET` no request is pending. In `ST_HELD` a winner exists but it may not nest over the active handler. In `ST_NEST` a winner exists and may be taken now. Every state can move to every other state in a single cycle. The move to `ST_QUIET` is called *drain*, the move to `ST_HELD` is called *block*, and the move to `ST_NEST` is called *admit*. The move depends only on the current inputs and the stored configuration.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the outputs are all zero, every stored priority is 0x00 and the grouping field is 0.
- R2: The winner is the pending line with the numerically smallest stored priority. Among equal values, the lowest index wins.
- R3: Bits [3:0] of a written priority are discarded and stored as zero, so a write of 0x1C behaves exactly like a write of 0x10.
- R4: When `act_valid_i` is low, any valid winner raises `win_preempt_o`.
- R5: When a handler is active, `win_preempt_o` is high only if the winner's group part is strictly smaller than the group part of `act_prio_i`. Bits [3:0] of `act_prio_i` are ignored, and equal groups never preempt.
- R6: Grouping values 0 to 3 all place all four stored bits in the group part. For example, a winner at 0x00 preempts an active 0x10 handler, and a winner at 0x70 preempts an active 0x80 handler.
- R7: A grouping value g from 4 to 6 makes bits [g:0] the subpriority. Those bits still order winners but never cause preemption. For example, at g=4 a winner at 0x00 does not preempt an active 0x10 handler.
- R8: With a grouping value of 7 every bit is subpriority, so no request preempts an active handler.
- R9: Outputs are registered. Changes on `pend_i`, `act_valid_i` or `act_prio_i` appear one cycle later, and register writes appear two cycles after the write cycle.
- R10: When no line is pending, `win_valid_o` and `win_preempt_o` are 0 and `win_idx_o` is 0.
- R11: The write port uses these addresses: 0 to NUM_IRQ-1 select a line priority, NUM_IRQ selects the grouping field (data bits [2:0]), and every higher address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_IRQ | Pending request per line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (line priority, grouping field, or ignored) |
| wr_data_i | input | 8 | Write data |
| act_valid_i | input | 1 | A handler is currently running |
| act_prio_i | input | 8 | Priority of the running handler |
| win_valid_o | output | 1 | A pending winner exists |
| win_preempt_o | output | 1 | The winner may be taken now |
| win_idx_o | output | IDX_W | Index of the winner |

## Verification
Every result comes out of one register stage. A change on the pending or active inputs is therefore due at the first rising edge after the input is driven, and a register write is due one edge after that. The bench drives inputs on the falling edge and samples on the following falling edge, after exactly the edges the result needs. For the latency cases, it also samples one edge early and confirms that the old value is still held at that point.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int PRIO_W    = 8;
    localparam int IMPL_BITS = 4;
    localparam int GRP_W     = 3;

    localparam logic [PRIO_W-1:0] IMPL_MASK =
        ~((PRIO_W)'((1 << (PRIO_W - IMPL_BITS)) - 1));

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_HELD  = 2'd1,
        ST_NEST  = 2'd2
    } res_state_e;

    // Bits above the binary point: field value g leaves bits [7:g+1] in the group.
    function automatic logic [PRIO_W-1:0] group_mask(input logic [GRP_W-1:0] g);
        logic [PRIO_W:0] wide;
        wide = {(PRIO_W+1){1'b1}} << (int'(g) + 1);
        return wide[PRIO_W-1:0];
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [PRIO_W-1:0]           wr_data_i,
    output logic [NUM_IRQ*PRIO_W-1:0]   prio_flat_o,
    output logic [GRP_W-1:0]            grp_o
);

    localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(NUM_IRQ);

    logic [GRP_W-1:0] grp_q;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
            logic [PRIO_W-1:0] prio_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prio_q <= '0;
                end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
                    prio_q <= wr_data_i & IMPL_MASK;
                end
            end

            assign prio_flat_o[i*PRIO_W +: PRIO_W] = prio_q;

            // R3: unimplemented low bits never hold a one
            a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (prio_q & ~IMPL_MASK) == '0);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (wr_en_i && wr_addr_i == GRP_ADDR) begin
            grp_q <= wr_data_i[GRP_W-1:0];
        end
    end

    assign grp_o = grp_q;

    // R11: writes outside the grouping address leave the grouping field alone
    a_r11_grp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != GRP_ADDR) |=> $stable(grp_q));

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_IRQ-1:0]          pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0]   prio_flat_i,
    output logic                        any_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           best_o
);

    // Ordering on the full value equals ordering on (group, subpriority);
    // scanning upward with a strict compare keeps the lowest index on ties.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        best_o = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend_i[i] && (!any_o || prio_flat_i[i*PRIO_W +: PRIO_W] < best_o)) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(i);
                best_o = prio_flat_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int  NUM_IRQ = 8,
    localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int ADDR_W  = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic               act_valid_i,
    input  logic [7:0]         act_prio_i,
    output logic               win_valid_o,
    output logic               win_preempt_o,
    output logic [IDX_W-1:0]   win_idx_o
);

    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [GRP_W-1:0]          grp;
    logic                      any_pend;
    logic [IDX_W-1:0]          best_idx;
    logic [PRIO_W-1:0]         best_prio;
    logic [PRIO_W-1:0]         gmask;
    logic                      may_nest;

    res_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    irq_prio_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .prio_flat_o (prio_flat),
        .grp_o       (grp)
    );

    irq_prio_arb #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
        .pend_i      (pend_i),
        .prio_flat_i (prio_flat),
        .any_o       (any_pend),
        .idx_o       (best_idx),
        .best_o      (best_prio)
    );

    assign gmask    = group_mask(grp);
    assign may_nest = !act_valid_i ||
                      ((best_prio & gmask) < (act_prio_i & IMPL_MASK & gmask));

    // Next-state: drain / block / admit
    always_comb begin
        state_d = state_q;
        idx_d   = '0;
        unique case (1'b1)
            !any_pend:            state_d = ST_QUIET;
            any_pend && !may_nest: begin state_d = ST_HELD; idx_d = best_idx; end
            any_pend && may_nest:  begin state_d = ST_NEST; idx_d = best_idx; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        win_valid_o   = 1'b0;
        win_preempt_o = 1'b0;
        unique case (state_q)
            ST_QUIET: ;
            ST_HELD:  win_valid_o = 1'b1;
            ST_NEST:  begin win_valid_o = 1'b1; win_preempt_o = 1'b1; end
            default:  ;
        endcase
        win_idx_o = idx_q;
    end

    // R5: a preempt indication always comes with a winner
    a_r5_preempt_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        win_preempt_o |-> win_valid_o);

    // R2: the reported winner was pending on the evaluated cycle
    a_r2_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> ((($past(pend_i) >> win_idx_o) & NUM_IRQ'(1)) != '0));

    // R10: quiet state reports index zero
    a_r10_quiet_index: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_o |-> (win_idx_o == '0 && !win_preempt_o));

    // R8: all-subpriority grouping never nests over an active handler
    a_r8_no_nest_flat: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp) == 3'd7 && $past(act_valid_i)) |-> !win_preempt_o);

    // R4: with no handler running any winner may be taken
    a_r4_idle_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(act_valid_i) && win_valid_o) |-> win_preempt_o);

endmodule

// File: tb/irq_prio_resolver_bench.sv
`timescale 1ns/1ps
module irq_prio_resolver_bench;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       act_valid = 1'b0;
    logic [7:0] act_prio = '0;
    logic       win_valid, win_preempt;
    logic [2:0] win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_resolver #(.NUM_IRQ(N)) u_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .act_valid_i(act_valid),
        .act_prio_i(act_prio), .win_valid_o(win_valid),
        .win_preempt_o(win_preempt), .win_idx_o(win_idx)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] pend;
        logic       av;
        logic [7:0] ap;
        logic [2:0] g;
        logic       ev;
        logic [2:0] ei;
        logic       ep;
    } vec_t;

    // Priorities programmed: 0:30 1:10 2:20 3:1C->10 4:50 5:0F->00 6:70 7:F0
    localparam vec_t VEC [17] = '{
        '{4'd10, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, 3'd0, 1'b0}, // R10
        '{4'd4,  8'h01, 1'b0, 8'h00, 3'd0, 1'b1, 3'd0, 1'b1}, // R4
        '{4'd2,  8'h0A, 1'b0, 8'h00, 3'd0, 1'b1, 3'd1, 1'b1}, // R2 tie
        '{4'd5,  8'h0E, 1'b1, 8'h20, 3'd0, 1'b1, 3'd1, 1'b1}, // R5
        '{4'd5,  8'h04, 1'b1, 8'h20, 3'd0, 1'b1, 3'd2, 1'b0}, // R5 equal
        '{4'd6,  8'h21, 1'b1, 8'h10, 3'd3, 1'b1, 3'd5, 1'b1}, // R6
        '{4'd7,  8'h21, 1'b1, 8'h10, 3'd4, 1'b1, 3'd5, 1'b0}, // R7
        '{4'd7,  8'h01, 1'b1, 8'h10, 3'd4, 1'b1, 3'd0, 1'b0}, // R7
        '{4'd7,  8'h04, 1'b1, 8'h50, 3'd4, 1'b1, 3'd2, 1'b1}, // R7
        '{4'd8,  8'h20, 1'b1, 8'hF0, 3'd7, 1'b1, 3'd5, 1'b0}, // R8
        '{4'd4,  8'h20, 1'b0, 8'h00, 3'd7, 1'b1, 3'd5, 1'b1}, // R4
        '{4'd5,  8'h80, 1'b1, 8'hF0, 3'd0, 1'b1, 3'd7, 1'b0}, // R5
        '{4'd6,  8'hC0, 1'b1, 8'h80, 3'd2, 1'b1, 3'd6, 1'b1}, // R6
        '{4'd7,  8'h10, 1'b1, 8'h80, 3'd5, 1'b1, 3'd4, 1'b1}, // R7
        '{4'd7,  8'h80, 1'b1, 8'h40, 3'd6, 1'b1, 3'd7, 1'b0}, // R7
        '{4'd5,  8'h04, 1'b1, 8'h2F, 3'd0, 1'b1, 3'd2, 1'b0}, // R5 low bits
        '{4'd3,  8'h0A, 1'b1, 8'h10, 3'd0, 1'b1, 3'd1, 1'b0}  // R3
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic chk_out(input string req, input int v, input int p, input int i);
        chk(req, "valid", int'(win_valid), v);
        chk(req, "preempt", int'(win_preempt), p);
        chk(req, "index", int'(win_idx), i);
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(input logic [7:0] p, input logic av, input logic [7:0] ap);
        pend = p; act_valid = av; act_prio = ap;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_out("R1", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1", 0, 0, 0);
        // R1: all priorities zero, grouping 0 -> idx0, 0 < 0x10 preempts
        apply(8'h81, 1'b1, 8'h10);
        chk_out("R1", 1, 1, 0);

        wr(4'd0, 8'h30); wr(4'd1, 8'h10); wr(4'd2, 8'h20); wr(4'd3, 8'h1C);
        wr(4'd4, 8'h50); wr(4'd5, 8'h0F); wr(4'd6, 8'h70); wr(4'd7, 8'hF0);

        for (int r = 0; r < 17; r++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", VEC[r].req, r);
            wr(4'd8, {5'd0, VEC[r].g});
            apply(VEC[r].pend, VEC[r].av, VEC[r].ap);
            chk_out(tag, int'(VEC[r].ev), int'(VEC[r].ep), int'(VEC[r].ei));
        end

        // R11: out-of-range writes ignored (grouping stays 0, priorities kept)
        wr(4'd15, 8'h07);
        wr(4'd9, 8'h00);
        apply(8'h06, 1'b1, 8'h30);
        chk_out("R11", 1, 1, 1);

        // R9: pending change lands one edge later
        apply(8'h80, 1'b1, 8'h10);
        chk_out("R9", 1, 0, 7);
        pend = 8'h00;
        #1;
        chk("R9", "valid before edge", int'(win_valid), 1);
        @(posedge clk); @(negedge clk);
        chk("R9", "valid after edge", int'(win_valid), 0);
        // R9: a priority write lands two edges later
        apply(8'h80, 1'b1, 8'h10);
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'h00;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R9", "preempt one edge after write", int'(win_preempt), 0);
        @(posedge clk); @(negedge clk);
        chk("R9", "preempt two edges after write", int'(win_preempt), 1);

        // R1: reset mid-run clears grouping and priorities
        wr(4'd8, 8'h07);
        rst_n = 1'b0;
        #1;
        chk_out("R1", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h81, 1'b1, 8'h10);
        chk_out("R1", 1, 1, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule